// File: doc/BRIEF.md
# Toggle-Strobed Watchdog Timer

This block supervises a processor through a single strobe line. Software is expected to change the level of the strobe regularly. Every change, whether the line goes up or down, restarts an internal cycle counter. When the counter runs a full timeout window without seeing a change, the block emits a one-cycle expiry request. A downstream reset sequencer turns that request into a timed system reset.

The strobe is asynchronous to the block clock, so it passes through a two-flop synchronizer before its transitions are detected. A strobe held at a constant level does not keep the watchdog quiet, because only transitions restart the count. The enable input stands for a strobe line that has been left unconnected. While the enable is low, the watchdog is idle. While the block reset is high, which covers the whole time the system sits in reset, the counter stays at zero.

The timeout is given in clock cycles. The default is sized for a 1.6 s window at a 125 MHz clock, and an integrator picks a value between 1.1 s and 2.3 s worth of cycles.

Top module: `toggle_watchdog`

## Requirements
- R1: While `rst` is high, `expire_o` is low and the count is zero. With the strobe low, the first expiry appears on the TIMEOUT_CYCLES-th rising clock edge after the last edge at which `rst` was sampled high.
- R2: A low-to-high change of `wd_strobe_i` restarts the count. A change first sampled at edge k takes effect at edge k+2, and the next possible expiry is at edge k+2+TIMEOUT_CYCLES.
- R3: A high-to-low change of `wd_strobe_i` restarts the count with the same k+2 timing as R2.
- R4: A strobe held at a constant level, high or low, does not prevent expiry. The expiry arrives TIMEOUT_CYCLES edges after the last restart.
- R5: `expire_o` is high for exactly one cycle. The count returns to zero on that same edge, so with no strobe activity the expiry repeats every TIMEOUT_CYCLES cycles.
- R6: While `wd_enable_i` is low, `expire_o` stays low, the count is held at zero and strobe changes have no effect. If the enable is first sampled high at edge e, the first expiry is at edge e-1+TIMEOUT_CYCLES.
- R7: When a strobe restart takes effect on the same edge that the count would reach its limit, the restart wins. No expiry is raised, and the next one is TIMEOUT_CYCLES edges later. A restart that takes effect one edge after an expiry does not cancel that expiry.
- R8: Asserting `rst` in the middle of a count drops any pending expiry. Counting restarts from zero after release, with the R1 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; high for as long as the system is in reset |
| wd_strobe_i | input | 1 | Asynchronous strobe from the processor; either transition restarts the count |
| wd_enable_i | input | 1 | High when the strobe is connected; low disables the watchdog |
| expire_o | output | 1 | Registered one-cycle request for a watchdog reset |

## Verification
Two functions can meet on the same edge: a restart caused by a strobe transition, and the terminal count that raises the expiry. The bench places a strobe change so that its restart lands exactly on the edge the expiry is due. It then places a second change so that its restart lands one edge after an expiry. The scoreboard expects no pulse in the first case. In the second case it expects the pulse on time, followed by a new window measured from the late restart. Any pulse the queue does not predict, and any predicted pulse that never comes, counts as a miscompare.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // What the timeout counter does on the next edge
  typedef enum logic [1:0] {
    ACT_HOLD_ZERO = 2'd0,
    ACT_COUNT     = 2'd1,
    ACT_FIRE      = 2'd2
  } cnt_act_e;

  // Counter width able to hold values 0 .. limit-1
  function automatic int unsigned cnt_bits(input longint unsigned limit);
    if (limit < 3) return 1;
    return $clog2(limit);
  endfunction

endpackage

// File: rtl/wdt_strobe_edge.sv
module wdt_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic toggle_o
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         hist_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= strobe_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[TOP-1:0], strobe_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= sync_q[TOP];
  end

  // Either direction of change counts as a kick
  assign toggle_o = sync_q[TOP] ^ hist_q;

  // Reset leaves synchronizer quiet: no kick on the first edge out of reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> !toggle_o);

endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
  parameter int unsigned CW             = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic clear_i,
  output logic expire_o
);

  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  cnt_act_e      act;

  always_comb begin
    if (!enable_i || clear_i)  act = ACT_HOLD_ZERO;
    else if (cnt_q == LAST)    act = ACT_FIRE;
    else                       act = ACT_COUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      case (act)
        ACT_HOLD_ZERO: begin
          cnt_q    <= '0;
          expire_o <= 1'b0;
        end
        ACT_FIRE: begin
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end
        default: begin
          cnt_q    <= cnt_q + CW'(1);
          expire_o <= 1'b0;
        end
      endcase
    end
  end

  p_reset_holds_r1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && !expire_o));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  p_pulse_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> cnt_q == '0);

  p_disable_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!expire_o && cnt_q == '0));

  p_kick_wins_r7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!expire_o && cnt_q == '0));

endmodule

// File: rtl/toggle_watchdog.sv
module toggle_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 200_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wd_strobe_i,
  input  logic wd_enable_i,
  output logic expire_o
);

  localparam int unsigned CW = cnt_bits(longint'(TIMEOUT_CYCLES));

  logic kick;

  wdt_strobe_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (wd_strobe_i),
    .toggle_o (kick)
  );

  wdt_timeout_ctr #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CW            (CW)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .enable_i (wd_enable_i),
    .clear_i  (kick),
    .expire_o (expire_o)
  );

  // Level-held strobe with kicks absent must still let pulses through; here:
  // a pulse is never raised the edge right after the block left reset
  p_no_pulse_at_release_r8: assert property (@(posedge clk)
    rst |=> !expire_o);

  p_pulse_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> $past(wd_enable_i));

endmodule

// File: tb/test_toggle_watchdog.sv
module test_toggle_watchdog;

  localparam int T = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic en = 1'b1;
  logic expire;

  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  toggle_watchdog #(
    .TIMEOUT_CYCLES(T),
    .SYNC_STAGES   (2)
  ) i_toggle_watchdog (
    .clk         (clk),
    .rst         (rst),
    .wd_strobe_i (strobe),
    .wd_enable_i (en),
    .expire_o    (expire)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_pulse(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops predicted expiry cycles and compares with observed pulses
  always @(negedge clk) begin
    if (!done) begin
      if (expire === 1'b1) begin
        checks++;
        if (exp_q.size() == 0) begin
          errs++;
          $display("FAIL R7 unexpected expiry: actual cycle %0d expected none", cyc);
        end else begin
          if (exp_q[0] != cyc) begin
            errs++;
            $display("FAIL %s expiry cycle: actual %0d expected %0d", tag_q[0], cyc, exp_q[0]);
          end
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (exp_q.size() > 0 && cyc >= exp_q[0]) begin
        checks++;
        errs++;
        $display("FAIL %s missing expiry: actual none expected cycle %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    int p;
    // R1: reset state
    tick(2);
    for (int i = 0; i < 3; i++) begin
      chk(expire == 1'b0, "R1 reset state", int'(expire), 0);
      tick(1);
    end
    c = cyc;
    rst = 1'b0;                        // last high edge = c
    expect_pulse(c + T, "R1");
    expect_pulse(c + 2 * T, "R5");
    tick(2 * T + 3);
    // R6: disable, strobe changes ignored
    en = 1'b0;
    tick(5);
    for (int i = 0; i < 4; i++) begin
      strobe = ~strobe;
      tick(T / 2);
    end
    tick(2 * T);
    chk(expire == 1'b0, "R6 disabled output", int'(expire), 0);
    c = cyc;
    en = 1'b1;                         // first high edge = c+1
    // R2 R3: periodic kicks in both directions suppress expiry
    tick(T / 2);
    for (int i = 0; i < 8; i++) begin
      strobe = ~strobe;                // rising then falling alternately
      tick(T / 2);
    end
    chk(expire == 1'b0, "R2 R3 kicks hold off", int'(expire), 0);
    c = cyc;
    strobe = ~strobe;                  // sampled at c+1, takes effect c+3
    p = c + 3 + T;
    expect_pulse(p, "R2");
    expect_pulse(p + T, "R4");         // strobe now level-held
    tick(p + T - cyc + 2);
    // R7: kick landing on the terminal edge wins
    p = p + 2 * T;                     // would-be pulse
    tick(p - 3 - cyc);
    strobe = ~strobe;                  // takes effect at p
    p = p + T;
    expect_pulse(p, "R7 kick wins");
    // R7: kick one edge late does not cancel
    tick(p - 2 - cyc);
    strobe = ~strobe;                  // takes effect at p+1
    expect_pulse(p + 1 + T, "R7 late kick");
    tick(p + 1 + T - cyc + T / 2);
    // R8: reset mid count
    rst = 1'b1;
    strobe = 1'b0;
    tick(1);
    chk(expire == 1'b0, "R8 reset mid count", int'(expire), 0);
    tick(3);
    chk(expire == 1'b0, "R8 held in reset", int'(expire), 0);
    c = cyc;
    rst = 1'b0;
    expect_pulse(c + T, "R8");
    tick(T + 3);
    en = 1'b0;
    tick(T + 5);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule